// File: doc/BRIEF.md
# Triple-Coded Overhead Frame Multiplexer

This block merges fourteen slow data channels, one overhead channel and one frame-alignment channel into a single serial bit stream. It emits one bit per clock. Bits are grouped into rows of sixteen positions, and sixteen rows make a major frame of 256 bits. One fixed row position carries the overhead channel and another carries an alignment sequence supplied from outside. The other fourteen positions each belong to one data channel. Data bits are taken from the channels through per-channel read strobes, so an external elastic store sees exactly how many bits were consumed.

A channel whose store runs low asks for a stuff, and a channel whose store runs high asks for a spill. At the first cycle of each major frame, at most one requesting channel is chosen in round-robin order and acknowledged. During that frame, the sixteen overhead bits describe the choice. They carry the channel address, each bit sent three times so that the far end can decode it by majority vote, then the command bit sent three times, then one unprotected bit. For a spill, that last bit holds an extra data bit read from the channel. For a stuff, the channel's slot in the last row carries a dummy bit and no data is read. The fixed overhead costs 32 of the 256 bits, which leaves 87.5 % of the frame for payload. With one service per frame, each channel can track about 1/224 of rate offset when every channel needs service.

Top module: `frame_mux`

## Requirements
- R1: A major frame is 256 cycles long. `frame_start_o` is high in the first cycle of each frame and low in the other 255. The first frame begins in the first cycle after reset is released.
- R2: Row position 16 (counting positions 1 to 16) outputs `sync_bit_i`, and `sync_rd_o` is high in exactly those cycles.
- R3: Row positions 1–7 carry channels 0–6 and positions 9–15 carry channels 7–13. In such a slot `ser_o` equals that channel's `ch_data_i` bit and that channel's `ch_rd_o` bit is high.
- R4: In overhead rows 1–12 (position 8), the 4-bit address is sent MSB first, each bit on three consecutive rows. The address is the channel index plus 1. When no channel is serviced, the address is 0.
- R5: Overhead rows 13–15 each carry the command bit: 1 for spill, 0 for stuff. When no channel is serviced, the bit is 0.
- R6: Overhead row 16 carries the serviced channel's `ch_data_i` bit and pulses its `ch_rd_o` when the command is spill. Otherwise it outputs 0 and no read strobe.
- R7: For a stuff, the serviced channel's slot in row 16 outputs 0 and its `ch_rd_o` stays low.
- R8: Requests are sampled only in the first cycle of a frame. `ack_o` is one-hot for the chosen channel in that cycle and zero in every other cycle. Requests that come and go within a frame have no effect.
- R9: The search starts at the channel after the one last granted, wrapping from 13 to 0. After reset, the search starts at channel 0.
- R10: When a channel asserts both stuff and spill, the command is spill.
- R11: At most one bit of `ch_rd_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_data_i | input | 14 | Current data bit of each channel |
| stuff_req_i | input | 14 | Per-channel stuff request |
| spill_req_i | input | 14 | Per-channel spill request |
| sync_bit_i | input | 1 | Next alignment sequence bit |
| ser_o | output | 1 | Serial output stream |
| frame_start_o | output | 1 | First cycle of a major frame |
| ch_rd_o | output | 14 | Per-channel read strobe |
| ack_o | output | 14 | Grant of a request, one-hot, in the frame start cycle |
| sync_rd_o | output | 1 | Alignment bit consumed |

## Verification
The bench builds the block with its defaults: fourteen channels, a 4-bit address and threefold repetition. This gives the full 16 × 16 frame, so every row, slot and overhead field is reached. Every bit of several whole frames is compared against a model built from the slot map. Those frames cover idle, stuff, spill, both requests on one channel, wrap-around of the round-robin search, the edge channels 0 and 13, and a request pulse that falls inside a frame.

// File: rtl/fmux_pkg.sv
package fmux_pkg;
  typedef enum logic [1:0] {SLOT_DATA, SLOT_OVH, SLOT_SYNC} slot_kind_e;

  function automatic slot_kind_e kind_of(int col, int ovh_col, int sync_col);
    if (col == sync_col) return SLOT_SYNC;
    if (col == ovh_col) return SLOT_OVH;
    return SLOT_DATA;
  endfunction
endpackage

// File: rtl/slot_counter.sv
module slot_counter #(
  parameter int ROW_LEN = 16,
  parameter int ROWS    = 16,
  localparam int CW = $clog2(ROW_LEN),
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] col_o,
  output logic [RW-1:0] row_o,
  output logic          frame_start_o,
  output logic          last_row_o
);
  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;
  logic          col_end, row_end;

  assign col_end = (col_q == CW'(ROW_LEN-1));
  assign row_end = (row_q == RW'(ROWS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (col_end) begin
      col_q <= '0;
      row_q <= row_end ? '0 : row_q + 1'b1;
    end else begin
      col_q <= col_q + 1'b1;
    end
  end

  assign col_o         = col_q;
  assign row_o         = row_q;
  assign frame_start_o = (col_q == '0) && (row_q == '0);
  assign last_row_o    = row_end;

  a_r1_frame_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_end && row_end) |=> (col_q == '0 && row_q == '0));
  a_r1_row_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !col_end |=> $stable(row_q));
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N = 14,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          en_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    int c;
    valid_o = 1'b0;
    idx_o   = '0;
    for (int off = 1; off <= N; off++) begin
      c = int'(ptr_q) + off;
      if (c >= N) c = c - N;
      if (!valid_o && req_i[IW'(c)]) begin
        valid_o = 1'b1;
        idx_o   = IW'(c);
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_grant
    assign grant_o[g] = valid_o && (idx_o == IW'(g));
  end

  // reset value makes the first search start at channel 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ptr_q <= IW'(N-1);
    else if (en_i && valid_o)   ptr_q <= idx_o;
  end

  a_r8_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
  a_r8_grant_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~req_i) == '0);
  a_r9_ptr_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_o) |=> (ptr_q == $past(idx_o)));
endmodule

// File: rtl/overhead_coder.sv
module overhead_coder #(
  parameter int ADDR_W = 4,
  parameter int REP    = 3,
  localparam int ROWS = ADDR_W*REP + REP + 1,
  localparam int RW   = $clog2(ROWS)
) (
  input  logic [RW-1:0]     row_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cmd_i,
  input  logic              spill_bit_i,
  output logic              bit_o
);
  localparam int ADDR_ROWS = ADDR_W*REP;

  always_comb begin
    int r;
    r     = int'(row_i);
    bit_o = spill_bit_i;
    if (r < ADDR_ROWS) begin
      bit_o = 1'b0;
      for (int i = 0; i < ADDR_W; i++)
        if (r / REP == ADDR_W-1-i) bit_o = addr_i[i];
    end else if (r < ADDR_ROWS + REP) begin
      bit_o = cmd_i;
    end
  end
endmodule

// File: rtl/frame_mux.sv
module frame_mux #(
  parameter int N_CH   = 14,
  parameter int ADDR_W = 4,
  parameter int REP    = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] ch_data_i,
  input  logic [N_CH-1:0] stuff_req_i,
  input  logic [N_CH-1:0] spill_req_i,
  input  logic            sync_bit_i,
  output logic            ser_o,
  output logic            frame_start_o,
  output logic [N_CH-1:0] ch_rd_o,
  output logic [N_CH-1:0] ack_o,
  output logic            sync_rd_o
);
  import fmux_pkg::*;

  localparam int ROW_LEN  = N_CH + 2;
  localparam int ROWS     = ADDR_W*REP + REP + 1;
  localparam int OVH_COL  = N_CH / 2;
  localparam int SYNC_COL = ROW_LEN - 1;
  localparam int CW       = $clog2(ROW_LEN);
  localparam int RW       = $clog2(ROWS);
  localparam int IW       = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic [CW-1:0]   col;
  logic [RW-1:0]   row;
  logic            fstart, last_row;
  logic [N_CH-1:0] grant;
  logic [IW-1:0]   gidx;
  logic            gvalid;
  logic            sel_valid_q, sel_spill_q;
  logic [IW-1:0]   sel_idx_q;
  logic [ADDR_W-1:0] addr;
  logic            cmd, spill_bit, ovh_bit;
  logic [IW-1:0]   ch;
  slot_kind_e      kind;

  slot_counter #(.ROW_LEN(ROW_LEN), .ROWS(ROWS)) u_cnt (
    .clk_i, .rst_ni, .col_o(col), .row_o(row),
    .frame_start_o(fstart), .last_row_o(last_row)
  );

  rr_arbiter #(.N(N_CH)) u_arb (
    .clk_i, .rst_ni, .req_i(stuff_req_i | spill_req_i), .en_i(fstart),
    .grant_o(grant), .idx_o(gidx), .valid_o(gvalid)
  );

  // selection is held for the whole frame that carries its command
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_valid_q <= 1'b0;
      sel_spill_q <= 1'b0;
      sel_idx_q   <= '0;
    end else if (fstart) begin
      sel_valid_q <= gvalid;
      sel_spill_q <= gvalid && spill_req_i[gidx];
      sel_idx_q   <= gidx;
    end
  end

  assign addr      = sel_valid_q ? ADDR_W'(sel_idx_q) + 1'b1 : '0;
  assign cmd       = sel_valid_q && sel_spill_q;
  assign spill_bit = cmd && ch_data_i[sel_idx_q];

  overhead_coder #(.ADDR_W(ADDR_W), .REP(REP)) u_ovh (
    .row_i(row), .addr_i(addr), .cmd_i(cmd), .spill_bit_i(spill_bit), .bit_o(ovh_bit)
  );

  assign kind = kind_of(int'(col), OVH_COL, SYNC_COL);
  assign ch   = IW'((col < CW'(OVH_COL)) ? col : col - 1'b1);

  always_comb begin
    ser_o     = 1'b0;
    ch_rd_o   = '0;
    sync_rd_o = 1'b0;
    case (kind)
      SLOT_SYNC: begin
        ser_o     = sync_bit_i;
        sync_rd_o = 1'b1;
      end
      SLOT_OVH: begin
        ser_o = ovh_bit;
        if (last_row && cmd) ch_rd_o[sel_idx_q] = 1'b1;
      end
      default: begin
        if (!(last_row && sel_valid_q && !sel_spill_q && ch == sel_idx_q)) begin
          ser_o       = ch_data_i[ch];
          ch_rd_o[ch] = 1'b1;
        end
      end
    endcase
  end

  assign frame_start_o = fstart;
  assign ack_o         = fstart ? grant : '0;

  a_r11_one_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_rd_o));
  a_r2_sync_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rd_o |-> (ch_rd_o == '0));
  a_r8_ack_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o != '0) |-> frame_start_o);
  a_r10_spill_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ack_o & spill_req_i) != '0) |=> sel_spill_q);
  a_r8_sel_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fstart |=> $stable(sel_idx_q) && $stable(sel_valid_q));
endmodule

// File: tb/frame_mux_test.sv
`timescale 1ns/1ps
module frame_mux_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [13:0] ch_data = '0, stuff_req = '0, spill_req = '0;
  logic        sync_bit = 0;
  logic        ser, fstart, sync_rd;
  logic [13:0] ch_rd, ack;
  int total = 0, bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  frame_mux uut (
    .clk_i(clk), .rst_ni(rst_n), .ch_data_i(ch_data), .stuff_req_i(stuff_req),
    .spill_req_i(spill_req), .sync_bit_i(sync_bit), .ser_o(ser),
    .frame_start_o(fstart), .ch_rd_o(ch_rd), .ack_o(ack), .sync_rd_o(sync_rd)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step_data();
    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ch_data  = lfsr[13:0] ^ {lfsr[0], lfsr[15:3]};
    sync_bit = lfsr[7];
  endtask

  // one whole frame; reqs are offered in the frame start cycle only
  task automatic run_frame(logic [13:0] st, logic [13:0] sp, bit ev, int ech, bit esp,
                           string tag, bit glitch);
    int col, row, ch, a;
    logic eb;
    logic [13:0] erd;
    stuff_req = st;
    spill_req = sp;
    @(negedge clk);
    while (!fstart) @(negedge clk);
    for (int k = 0; k < 256; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 1) begin stuff_req = '0; spill_req = '0; end
      if (glitch && k == 50) stuff_req[4] = 1'b1;
      if (glitch && k == 60) stuff_req[4] = 1'b0;
      step_data();
      #1;
      col = k % 16; row = k / 16;
      erd = '0;
      chk("R1", "frame_start", fstart, k == 0);
      chk((k == 0) ? tag : "R8", "ack", ack, (k == 0 && ev) ? 14'(1 << ech) : 14'd0);
      if (col == 15) begin
        chk("R2", "sync bit", ser, sync_bit);
        chk("R2", "sync_rd", sync_rd, 1);
      end else begin
        chk("R2", "sync_rd idle", sync_rd, 0);
        if (col == 7) begin
          a = ev ? ech + 1 : 0;
          if (row < 12) chk("R4", "address bit", ser, (a >> (3 - row / 3)) & 1);
          else if (row < 15) chk("R5", "command bit", ser, ev && esp);
          else begin
            eb = (ev && esp) ? ch_data[ech] : 1'b0;
            if (ev && esp) erd[ech] = 1'b1;
            chk("R6", "spill bit", ser, eb);
          end
        end else begin
          ch = (col < 7) ? col : col - 1;
          if (row == 15 && ev && !esp && ch == ech) begin
            chk("R7", "stuffed bit", ser, 0);
          end else begin
            erd[ch] = 1'b1;
            chk("R3", "data bit", ser, ch_data[ch]);
          end
        end
      end
      chk("R11", "read strobes", ch_rd, erd);
    end
  endtask

  initial begin
    #(4*40000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "frame_start in reset", fstart, 1);
    chk("R8", "ack in reset", ack, 0);
    rst_n = 1;
    run_frame('0, '0, 0, 0, 0, "R4", 0);                        // idle
    run_frame(14'h0008, '0, 1, 3, 0, "R8", 0);                  // stuff ch3
    run_frame('0, 14'h0400, 1, 10, 1, "R9", 0);                 // spill ch10
    run_frame(14'h0020, 14'h0020, 1, 5, 1, "R10", 0);           // both on ch5
    run_frame(14'h1004, '0, 1, 12, 0, "R9", 0);                 // after 5 -> 12
    run_frame('0, 14'h1004, 1, 2, 1, "R9", 0);                  // wrap -> 2
    run_frame('0, 14'h2000, 1, 13, 1, "R9", 0);                 // edge ch13
    run_frame(14'h2001, '0, 1, 0, 0, "R9", 0);                  // after 13 -> 0
    run_frame('0, '0, 0, 0, 0, "R8", 1);                        // mid-frame pulse
    run_frame('0, '0, 0, 0, 0, "R8", 0);                        // pulse left no trace
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule